// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core

This block models a synchronous pipelined SRAM with a shared data path for reads and writes and a fixed burst of two words per command. Each burst address selects a pair of storage words. The double-rate interface is modelled with one fast clock, `clk2x`, that runs at twice the command rate. The input `k_rise` is high during each fast cycle whose closing edge stands for a rising input-clock edge. The other fast cycles stand for falling edges. Commands are taken only on the rising-phase edges.

A read returns its two words on consecutive fast cycles after a fixed pipeline delay. A write takes its two data words late, on the two edges that follow the next rising edge. The write's address and data are held in a pending buffer and go into the array one rising edge later. A read that hits that buffer gets the new bytes merged in. The output timing mode is taken from `single_clk` while reset is asserted. In the single-clock mode the outputs follow the input clock. Otherwise they come one fast cycle later, standing in for separate output clocks.

Top module: `ddr_b2_sram`

## Requirements
- R1: A command is taken at a rising-phase edge (`k_rise`=1) with `ld`=1. `rw`=1 selects a read and `rw`=0 a write. Burst address A covers storage word 2A (beat 0) and then word 2A+1 (beat 1), and a read returns them in that order.
- R2: In single-clock mode, a read command taken at the end of fast cycle c drives beat 0 with `q_oe`=1 during cycle c+3 and beat 1 during cycle c+4.
- R3: In output-clock mode, each read word appears exactly one fast cycle later than under R2, that is during cycles c+4 and c+5.
- R4: Reads issued on consecutive rising phases keep `q_oe` high without a gap, giving one word on every fast cycle.
- R5: For a write command taken at the end of fast cycle c, beat 0 data and enables are sampled from cycle c+2 and beat 1 from cycle c+3.
- R6: `bwe[i]` enables the 9-bit lane at bits 9i to 9i+8 of its beat. A lane whose enable is 0 keeps its old contents.
- R7: Data presented outside a write's two data cycles has no effect on storage. So does a command pattern on a falling-phase cycle, and any cycle with `ld`=0.
- R8: Out of reset, and in every fast cycle where no read word is due, `q_oe` is 0 and `q_out` is all zero. After a read burst ends with no new read, the outputs go idle on the next cycle.
- R9: A read always returns the latest data written by earlier commands, including bytes still in the pending write buffer, merged lane by lane.
- R10: The timing mode is sampled from `single_clk` only while `rst_n` is low. Later changes of `single_clk` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, two edges per command period |
| rst_n | input | 1 | Active-low synchronous reset |
| k_rise | input | 1 | High in fast cycles that end on a rising input-clock edge |
| single_clk | input | 1 | Timing mode strap, sampled during reset (1 = single-clock) |
| ld | input | 1 | Load strobe, a command is present |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Burst address |
| bwe | input | NL | Per-lane write enables for the current data beat |
| d_in | input | NL*9 | Write data beat |
| q_out | output | NL*9 | Read data, zero when not driven |
| q_oe | output | 1 | Output driver enable |

## Verification
A read taken at the end of cycle c owes its words in cycles c+3 and c+4 in single-clock mode, and in c+4 and c+5 in output-clock mode. Write data for a command at c is due on the inputs in cycles c+2 and c+3. The bench keeps small rings indexed by cycle number. At each command it schedules the data cycles and fetch cycles. At the fetch cycle it takes a snapshot of its own memory model and stores it in the output slot due one or two cycles later. Every fast cycle it then compares the bus, sampled at the falling edge, with that slot, or with the idle value when nothing is due.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;
endpackage

// File: rtl/b2_array.sv
module b2_array #(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic                           clk,
    input  logic [AW:0]                    rd_idx,
    output logic [NL*ddr_b2_pkg::LANE_W-1:0] rd_word,
    input  logic                           we,
    input  logic [AW-1:0]                  wr_adr,
    input  logic [NL*ddr_b2_pkg::LANE_W-1:0] wd0,
    input  logic [NL*ddr_b2_pkg::LANE_W-1:0] wd1,
    input  logic [NL-1:0]                  wb0,
    input  logic [NL-1:0]                  wb1
);
    localparam int LW = ddr_b2_pkg::LANE_W;
    localparam int DW = NL * LW;
    localparam int NW = 2 ** (AW + 1);

    logic [DW-1:0] mem [0:NW-1];
    logic [DW-1:0] old0, old1, m0, m1;

    assign rd_word = mem[rd_idx];
    assign old0    = mem[{wr_adr, 1'b0}];
    assign old1    = mem[{wr_adr, 1'b1}];

    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign m0[l*LW +: LW] = wb0[l] ? wd0[l*LW +: LW] : old0[l*LW +: LW];
        assign m1[l*LW +: LW] = wb1[l] ? wd1[l*LW +: LW] : old1[l*LW +: LW];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wr_adr, 1'b0}] <= m0;
            mem[{wr_adr, 1'b1}] <= m1;
        end
    end
endmodule

// File: rtl/b2_wpath.sv
module b2_wpath #(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 k_rise,
    input  ddr_b2_pkg::cmd_e     cmd,
    input  logic [AW-1:0]        addr,
    input  logic [NL-1:0]        bwe,
    input  logic [NL*9-1:0]      d_in,
    output logic                 cm_we,
    output logic [AW-1:0]        cm_adr,
    output logic [NL*9-1:0]      cm_d0,
    output logic [NL*9-1:0]      cm_d1,
    output logic [NL-1:0]        cm_b0,
    output logic [NL-1:0]        cm_b1,
    output logic                 pend
);
    import ddr_b2_pkg::*;
    localparam int DW = NL * LANE_W;

    typedef struct packed {
        logic          wcmd;
        logic [AW-1:0] wadr;
        logic          pend;
        logic [AW-1:0] padr;
        logic          beat1;
        logic [DW-1:0] buf0;
        logic [DW-1:0] buf1;
        logic [NL-1:0] be0;
        logic [NL-1:0] be1;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (k_rise) begin
            st_d.wcmd  = (cmd == CMD_WR);
            if (cmd == CMD_WR) st_d.wadr = addr;
            st_d.pend  = st_q.wcmd;
            st_d.beat1 = st_q.wcmd;
            if (st_q.wcmd) begin
                st_d.padr = st_q.wadr;
                st_d.buf0 = d_in;
                st_d.be0  = bwe;
            end
        end else begin
            st_d.beat1 = 1'b0;
            if (st_q.beat1) begin
                st_d.buf1 = d_in;
                st_d.be1  = bwe;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cm_we  = k_rise && st_q.pend;
    assign cm_adr = st_q.padr;
    assign cm_d0  = st_q.buf0;
    assign cm_d1  = st_q.buf1;
    assign cm_b0  = st_q.be0;
    assign cm_b1  = st_q.be1;
    assign pend   = st_q.pend;

    // R5
    late_beat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.beat1 |-> !k_rise);

    // R7
    no_stray_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (k_rise && !st_q.wcmd) |=> !st_q.pend);
endmodule

// File: rtl/b2_rpath.sv
module b2_rpath #(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 k_rise,
    input  ddr_b2_pkg::cmd_e     cmd,
    input  logic [AW-1:0]        addr,
    input  logic                 sclk,
    input  logic                 pend,
    input  logic [AW-1:0]        padr,
    input  logic [NL*9-1:0]      pbuf,
    input  logic [NL-1:0]        pbe,
    output logic [AW:0]          rd_idx,
    input  logic [NL*9-1:0]      rd_word,
    output logic [NL*9-1:0]      q_out,
    output logic                 q_oe
);
    import ddr_b2_pkg::*;
    localparam int LW = LANE_W;
    localparam int DW = NL * LW;

    typedef struct packed {
        logic          rcmd;
        logic [AW-1:0] radr;
        logic          fb1;
        logic [AW-1:0] fadr;
        logic          fvld;
        logic [DW-1:0] fdat;
        logic          ovld;
        logic [DW-1:0] odat;
    } rst_t;

    rst_t st_d, st_q;
    logic          hit;
    logic [DW-1:0] merged;

    assign rd_idx = k_rise ? {st_q.radr, 1'b0} : {st_q.fadr, 1'b1};
    assign hit    = pend && (padr == st_q.radr);

    for (genvar l = 0; l < NL; l++) begin : g_merge
        assign merged[l*LW +: LW] = (hit && pbe[l]) ? pbuf[l*LW +: LW]
                                                    : rd_word[l*LW +: LW];
    end

    always_comb begin
        st_d      = st_q;
        st_d.ovld = st_q.fvld;
        st_d.odat = st_q.fdat;
        if (k_rise) begin
            st_d.rcmd = (cmd == CMD_RD);
            if (cmd == CMD_RD) st_d.radr = addr;
            st_d.fvld = st_q.rcmd;
            st_d.fb1  = st_q.rcmd;
            if (st_q.rcmd) begin
                st_d.fadr = st_q.radr;
                st_d.fdat = merged;
            end
        end else begin
            st_d.fvld = st_q.fb1;
            st_d.fb1  = 1'b0;
            if (st_q.fb1) st_d.fdat = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_oe  = sclk ? st_q.fvld : st_q.ovld;
    assign q_out = q_oe ? (sclk ? st_q.fdat : st_q.odat) : '0;

    // R1
    beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fb1 |=> st_q.fvld);

    // R2
    fetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (k_rise && st_q.rcmd) |=> (st_q.fvld && st_q.fb1));

    // R3
    late_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && st_q.fvld) |=> q_oe);
endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram #(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic               clk2x,
    input  logic               rst_n,
    input  logic               k_rise,
    input  logic               single_clk,
    input  logic               ld,
    input  logic               rw,
    input  logic [AW-1:0]      addr,
    input  logic [NL-1:0]      bwe,
    input  logic [NL*9-1:0]    d_in,
    output logic [NL*9-1:0]    q_out,
    output logic               q_oe
);
    import ddr_b2_pkg::*;
    localparam int DW = NL * LANE_W;

    cmd_e          cmd;
    logic          sclk_q;
    logic          cm_we, pend;
    logic [AW-1:0] cm_adr;
    logic [DW-1:0] cm_d0, cm_d1, rd_word;
    logic [NL-1:0] cm_b0, cm_b1;
    logic [AW:0]   rd_idx;

    always_comb begin
        cmd = CMD_NOP;
        if (k_rise && ld) cmd = rw ? CMD_RD : CMD_WR;
    end

    always_ff @(posedge clk2x) begin
        if (!rst_n) sclk_q <= single_clk;
    end

    b2_wpath #(.AW(AW), .NL(NL)) u_wpath (
        .clk(clk2x), .rst_n(rst_n), .k_rise(k_rise), .cmd(cmd), .addr(addr),
        .bwe(bwe), .d_in(d_in), .cm_we(cm_we), .cm_adr(cm_adr),
        .cm_d0(cm_d0), .cm_d1(cm_d1), .cm_b0(cm_b0), .cm_b1(cm_b1),
        .pend(pend)
    );

    b2_array #(.AW(AW), .NL(NL)) u_array (
        .clk(clk2x), .rd_idx(rd_idx), .rd_word(rd_word), .we(cm_we),
        .wr_adr(cm_adr), .wd0(cm_d0), .wd1(cm_d1), .wb0(cm_b0), .wb1(cm_b1)
    );

    b2_rpath #(.AW(AW), .NL(NL)) u_rpath (
        .clk(clk2x), .rst_n(rst_n), .k_rise(k_rise), .cmd(cmd), .addr(addr),
        .sclk(sclk_q), .pend(pend), .padr(cm_adr), .pbuf(cm_d0), .pbe(cm_b0),
        .rd_idx(rd_idx), .rd_word(rd_word), .q_out(q_out), .q_oe(q_oe)
    );

    // R10
    mode_hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        rst_n |=> $stable(sclk_q));
endmodule

// File: tb/ddr_b2_sram_bench.sv
module ddr_b2_sram_bench;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int DW = NL * 9;
    localparam int NW = 2 ** (AW + 1);
    localparam int CLK_PERIOD = 10;

    logic          clk2x = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_rise = 1'b0;
    logic          single_clk = 1'b1;
    logic          ld = 1'b0;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bwe = '0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] q_out;
    logic          q_oe;

    ddr_b2_sram #(.AW(AW), .NL(NL)) u_ddr_b2_sram (
        .clk2x(clk2x), .rst_n(rst_n), .k_rise(k_rise), .single_clk(single_clk),
        .ld(ld), .rw(rw), .addr(addr), .bwe(bwe), .d_in(d_in),
        .q_out(q_out), .q_oe(q_oe)
    );

    always #(CLK_PERIOD / 2) clk2x = ~clk2x;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int cyc = 0;
    int dly = 0;
    bit krise = 1'b1;
    string req = "R8";

    logic [DW-1:0] model [NW];
    bit            fq_v [8];
    logic [AW:0]   fq_i [8];
    bit            ex_v [8];
    logic [DW-1:0] ex_d [8];
    bit            pd_v [8];
    logic [AW:0]   pd_i [8];
    logic [DW-1:0] pd_d [8];
    logic [NL-1:0] pd_b [8];

    logic [DW-1:0] g_d0, g_d1;
    logic [NL-1:0] g_b0, g_b1;

    function automatic logic [DW-1:0] lmerge(logic [DW-1:0] o, logic [DW-1:0] n,
                                             logic [NL-1:0] be);
        logic [DW-1:0] r = o;
        for (int l = 0; l < NL; l++)
            if (be[l]) r[l*9 +: 9] = n[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int a, int b);
        return DW'(a * 36'h1234567 + b * 36'h0FEDCBA + 36'h3C3C3C3C3);
    endfunction

    task automatic step(input logic l, input logic r, input logic [AW-1:0] a);
        int s;
        @(negedge clk2x);
        s = cyc % 8;
        nchk++;
        if (ex_v[s]) begin
            if (q_oe !== 1'b1 || q_out !== ex_d[s]) begin
                nfail++;
                $display("FAIL %s %s cyc %0d: q_out=%h oe=%b expected %h oe=1",
                         req, (dly != 0) ? "R3" : "R2", cyc, q_out, q_oe, ex_d[s]);
            end
        end else if (q_oe !== 1'b0 || q_out !== '0) begin
            nfail++;
            $display("FAIL R8 %s cyc %0d: q_out=%h oe=%b expected 0 oe=0",
                     req, cyc, q_out, q_oe);
        end
        ex_v[s] = 1'b0;
        if (fq_v[s]) begin
            ex_v[(cyc + 1 + dly) % 8] = 1'b1;
            ex_d[(cyc + 1 + dly) % 8] = model[fq_i[s]];
            fq_v[s] = 1'b0;
        end
        if (pd_v[s]) begin
            d_in = pd_d[s];
            bwe  = pd_b[s];
            model[pd_i[s]] = lmerge(model[pd_i[s]], pd_d[s], pd_b[s]);
            pd_v[s] = 1'b0;
        end else begin
            d_in = DW'(cyc * 36'h9E3779B) ^ 36'h5A5A5A5A5;
            bwe  = '1;
        end
        k_rise = krise;
        ld     = l;
        rw     = r;
        addr   = a;
        if (krise && l) begin
            if (r) begin
                fq_v[(cyc + 2) % 8] = 1'b1; fq_i[(cyc + 2) % 8] = {a, 1'b0};
                fq_v[(cyc + 3) % 8] = 1'b1; fq_i[(cyc + 3) % 8] = {a, 1'b1};
            end else begin
                pd_v[(cyc + 2) % 8] = 1'b1; pd_i[(cyc + 2) % 8] = {a, 1'b0};
                pd_d[(cyc + 2) % 8] = g_d0; pd_b[(cyc + 2) % 8] = g_b0;
                pd_v[(cyc + 3) % 8] = 1'b1; pd_i[(cyc + 3) % 8] = {a, 1'b1};
                pd_d[(cyc + 3) % 8] = g_d1; pd_b[(cyc + 3) % 8] = g_b1;
            end
        end
        krise = ~krise;
        cyc++;
    endtask

    // kind: 0 idle, 1 read, 2 write; one rising and one falling phase
    task automatic cmd(input int kind, input int a, input logic [DW-1:0] d0,
                       input logic [DW-1:0] d1, input logic [NL-1:0] b0,
                       input logic [NL-1:0] b1);
        g_d0 = d0; g_d1 = d1; g_b0 = b0; g_b1 = b1;
        step(kind != 0, kind == 1, AW'(a));
        step(1'b0, 1'b0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(0, 0, '0, '0, '0, '0);
    endtask

    task automatic do_reset(input logic sc);
        @(negedge clk2x);
        rst_n = 1'b0; single_clk = sc; ld = 1'b0; k_rise = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fq_v[i] = 1'b0; ex_v[i] = 1'b0; pd_v[i] = 1'b0;
        end
        repeat (4) @(negedge clk2x);
        rst_n = 1'b1;
        cyc = 0; krise = 1'b1; dly = sc ? 0 : 1;
        @(posedge clk2x);
        #1;
        nchk++;
        if (q_oe !== 1'b0 || q_out !== '0) begin
            nfail++;
            $display("FAIL R8 reset: q_out=%h oe=%b expected 0 oe=0", q_out, q_oe);
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        do_reset(1'b1);

        req = "R1/R4/R5 sweep";
        for (int a = 0; a < 16; a++) cmd(2, a, pat(a, 0), pat(a, 1), '1, '1);
        idle(3);
        for (int a = 0; a < 16; a++) cmd(1, a, '0, '0, '0, '0);
        idle(3);

        req = "R6 lanes";
        for (int be = 0; be < 16; be++) begin
            cmd(2, 5, pat(be + 20, 0), pat(be + 20, 1), NL'(be), ~NL'(be));
            idle(1);
            cmd(1, 5, '0, '0, '0, '0);
            idle(2);
        end

        req = "R9 coherence";
        for (int a = 0; a < 16; a += 3) begin
            for (int gap = 0; gap < 3; gap++) begin
                cmd(2, a, pat(a + 40 + gap, 0), pat(a + 40 + gap, 1), 4'b1010, '1);
                idle(gap);
                cmd(1, a, '0, '0, '0, '0);
                idle(3);
            end
            cmd(1, a, '0, '0, '0, '0);
            cmd(2, a, pat(a + 60, 0), pat(a + 60, 1), 4'b0110, 4'b1001);
            cmd(1, a, '0, '0, '0, '0);
            cmd(2, a + 1, pat(a + 70, 0), pat(a + 70, 1), '1, '1);
            cmd(1, a + 1, '0, '0, '0, '0);
            idle(3);
        end

        req = "R7 ignore";
        for (int a = 0; a < 16; a++) begin
            step(1'b0, 1'b0, AW'(a));
            step(1'b1, 1'b0, AW'(a));
        end
        idle(2);
        for (int a = 0; a < 16; a++) cmd(1, a, '0, '0, '0, '0);
        idle(4);

        do_reset(1'b0);
        single_clk = 1'b1;
        req = "R3/R10 dual";
        for (int a = 0; a < 16; a++) cmd(1, a, '0, '0, '0, '0);
        idle(3);
        for (int a = 0; a < 16; a += 5) begin
            cmd(2, a, pat(a + 90, 0), pat(a + 90, 1), 4'b0011, 4'b1100);
            cmd(1, a, '0, '0, '0, '0);
            idle(1);
            cmd(1, a, '0, '0, '0, '0);
            idle(3);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk2x);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule